// File: doc/BRIEF.md
# Framed Synchronous Serial Receiver

This block is the receive half of a synchronous serial port. It watches a serial clock, a data line and a frame sync line. It finds the start of each frame, either from a rising edge on the frame sync line or from a bit pattern seen on the data line, and then assembles a set number of data words from the bit stream. Each finished word appears right-aligned on a 32-bit output with a one-cycle strobe. The bits that mark the start of a frame are kept in a separate sync word, and the block drives its own frame sync pulse of the programmed length.

The serial lines are sampled in the system clock domain. The block uses the rising edges of the serial clock, after a two-stage synchronizer, as bit strobes, so the serial clock must run well below the system clock. A loopback switch moves the clock, data and sync inputs together from the receive pins to the transmit pins, so the transmitter can be tested without external wiring. The configuration is taken only while the receiver is idle. A frame in progress always finishes with the settings it started with.

Top module: `sync_serial_rx`

## Requirements
- R1: A word holds `cfg_wlen`+1 bits (2 to 32). When its last bit is sampled, `word_data` shows the word in its low bits with every higher bit zero, and `word_valid` is high for exactly one system clock cycle.
- R2: With `cfg_msb_first`=1 the first bit of a word received lands in bit `cfg_wlen`. With it 0 the first bit received lands in bit 0.
- R3: After each transfer start exactly `cfg_nwords`+1 words are produced. The block then goes idle, and further data bits produce no word until the next start.
- R4: With `cfg_cmp_start`=0, a start happens at a serial clock rising edge where the frame sync is sampled high after being sampled low at the previous edge. The data bits on that edge and on the following L edges are sync bits, where L = `cfg_fslen` + 16×`cfg_fsext`. The first data bit is on the next edge.
- R5: When the sync bits are complete, `sync_data` holds the last min(L+1,16) sync bits, with the newest bit in bit 0 and the higher bits zero, and `sync_valid` pulses for one cycle.
- R6: With `cfg_cmp_start`=1 the idle receiver shifts in data bits. Let N = min(L+1,16). Once at least N bits have arrived since the block went idle, and the last N bits (newest in bit 0) equal the low N bits of `cmp_val0` or `cmp_val1`, `cmp_hit` and `sync_valid` pulse, `sync_data` takes those N bits, and the next bit is the first data bit.
- R7: Every transfer start raises `fs_drive` for exactly L+1 serial clock periods.
- R8: With `cfg_loop`=1 the clock, data and sync come from `tx_sclk`, `tx_sdata` and `tx_fsync`, and the `rx_*` lines have no effect.
- R9: A `cfg_wlen` of 0 is handled as 2-bit words and sets `cfg_error`, which stays high until reset.
- R10: A configuration change made after a frame has started does not affect that frame.
- R11: A frame sync rising edge seen while a frame is in progress does not restart the frame. It sets `overrun`, which stays high until reset.
- R12: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_sclk | input | 1 | Receive serial clock |
| rx_sdata | input | 1 | Receive serial data |
| rx_fsync | input | 1 | Receive frame sync |
| tx_sclk | input | 1 | Transmit serial clock (loopback source) |
| tx_sdata | input | 1 | Transmit serial data (loopback source) |
| tx_fsync | input | 1 | Transmit frame sync (loopback source) |
| cfg_wlen | input | 5 | Word length minus one |
| cfg_msb_first | input | 1 | 1: most significant bit first |
| cfg_nwords | input | 4 | Words per frame minus one |
| cfg_fslen | input | 4 | Sync length, low part |
| cfg_fsext | input | 4 | Sync length, high part (units of 16) |
| cfg_loop | input | 1 | Loopback select |
| cfg_cmp_start | input | 1 | 1: start on pattern match, 0: start on sync edge |
| cmp_val0 | input | 16 | First start pattern |
| cmp_val1 | input | 16 | Second start pattern |
| word_data | output | 32 | Received word, right-aligned |
| word_valid | output | 1 | One-cycle strobe for `word_data` |
| sync_data | output | 16 | Captured sync bits |
| sync_valid | output | 1 | One-cycle strobe for `sync_data` |
| cmp_hit | output | 1 | One-cycle pattern match pulse |
| fs_drive | output | 1 | Generated frame sync pulse |
| cfg_error | output | 1 | Sticky illegal word length flag |
| overrun | output | 1 | Sticky start-during-frame flag |

## Verification
The bench covers both ends of the word length: 32-bit words would lose the top bit if the assembler were one position short, and a zero length must fall back to 2-bit words rather than 1-bit words. It uses sync lengths above 16, where a capture that did not keep only the newest bits would return stale high bits. It also uses compare patterns with junk above the match width, where a missing mask would never match. Settings are changed in the middle of a frame and a spurious sync edge is injected during data: a design that read live settings or restarted on the edge would return a wrong word count or wrong words. In loopback runs the receive pins are driven with random toggling, so any leak through the line selection corrupts the data.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_SYNC = 2'd1,
    RX_DATA = 2'd2
  } rx_state_e;
endpackage

// File: rtl/sync_rx_front.sv
module sync_rx_front #(
  parameter int NL = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          use_tx,
  input  logic [NL-1:0] rx_lines,   // [0]=clock [1]=data [2]=sync
  input  logic [NL-1:0] tx_lines,
  output logic          bit_edge,
  output logic          bit_val,
  output logic          fs_val
);
  logic [NL-1:0] sel;
  logic [NL-1:0] st1, st2;
  logic          clk_prev;

  assign sel = use_tx ? tx_lines : rx_lines;

  for (genvar g = 0; g < NL; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) begin
        st1[g] <= 1'b0;
        st2[g] <= 1'b0;
      end else begin
        st1[g] <= sel[g];
        st2[g] <= st1[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_prev <= 1'b0;
      bit_edge <= 1'b0;
      bit_val  <= 1'b0;
      fs_val   <= 1'b0;
    end else begin
      clk_prev <= st2[0];
      bit_edge <= st2[0] & ~clk_prev;
      bit_val  <= st2[1];
      fs_val   <= st2[2];
    end
  end

  // R1
  edge_gap_chk: assert property (@(posedge clk) disable iff (rst)
    bit_edge |=> !bit_edge);
endmodule

// File: rtl/sync_rx_word.sv
module sync_rx_word #(
  parameter int DW  = 32,
  parameter int WLW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           bit_in,
  input  logic [WLW-1:0] wlen_m1,
  input  logic           msb_first,
  output logic           last,
  output logic [DW-1:0]  word_data,
  output logic           word_valid
);
  logic [WLW-1:0] bit_cnt;
  logic [DW-1:0]  acc, base, ins;

  assign base = (bit_cnt == '0) ? '0 : acc;
  assign ins  = msb_first ? {base[DW-2:0], bit_in}
                          : (base | (DW'(bit_in) << bit_cnt));
  assign last = (bit_cnt == wlen_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt    <= '0;
      acc        <= '0;
      word_data  <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (en) begin
        if (last) begin
          word_data  <= ins;
          word_valid <= 1'b1;
          bit_cnt    <= '0;
          acc        <= '0;
        end else begin
          acc     <= ins;
          bit_cnt <= bit_cnt + WLW'(1);
        end
      end
    end
  end

  // R1
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);
  // R1
  bitcnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    en |-> bit_cnt <= wlen_m1);
endmodule

// File: rtl/sync_rx_fsgen.sv
module sync_rx_fsgen #(
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          bit_edge,
  input  logic [LW-1:0] len,
  output logic          fs_out
);
  logic [LW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_out <= 1'b0;
      remain <= '0;
    end else if (start) begin
      fs_out <= 1'b1;
      remain <= len;
    end else if (bit_edge && fs_out) begin
      if (remain == '0) fs_out <= 1'b0;
      else remain <= remain - LW'(1);
    end
  end

  // R7
  fs_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fs_out) |-> $past(start));
  // R7
  fs_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(fs_out) |-> $past(bit_edge));
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
  import sync_rx_pkg::*;
#(
  parameter int DW  = 32,
  parameter int WLW = 5,
  parameter int NWW = 4,
  parameter int SW  = 16,
  parameter int FLW = 4,
  parameter int FEW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rx_sclk,
  input  logic           rx_sdata,
  input  logic           rx_fsync,
  input  logic           tx_sclk,
  input  logic           tx_sdata,
  input  logic           tx_fsync,
  input  logic [WLW-1:0] cfg_wlen,
  input  logic           cfg_msb_first,
  input  logic [NWW-1:0] cfg_nwords,
  input  logic [FLW-1:0] cfg_fslen,
  input  logic [FEW-1:0] cfg_fsext,
  input  logic           cfg_loop,
  input  logic           cfg_cmp_start,
  input  logic [SW-1:0]  cmp_val0,
  input  logic [SW-1:0]  cmp_val1,
  output logic [DW-1:0]  word_data,
  output logic           word_valid,
  output logic [SW-1:0]  sync_data,
  output logic           sync_valid,
  output logic           cmp_hit,
  output logic           fs_drive,
  output logic           cfg_error,
  output logic           overrun
);
  localparam int LW = FLW + FEW + 1;
  localparam int CW = $clog2(SW + 1);

  rx_state_e state;
  logic idle;
  assign idle = (state == RX_IDLE);

  // settings held for the frame in progress
  logic [WLW-1:0] a_wlen;  logic a_msb;  logic [NWW-1:0] a_nw;
  logic [LW-1:0]  a_len;   logic a_loop; logic a_cmp;
  logic [SW-1:0]  a_c0, a_c1;
  logic [LW-1:0]  live_len;
  logic [WLW-1:0] e_wlen, e_wfix;  logic e_msb; logic [NWW-1:0] e_nw;
  logic [LW-1:0]  e_len;   logic e_loop; logic e_cmp;
  logic [SW-1:0]  e_c0, e_c1;

  assign live_len = LW'(cfg_fslen) + (LW'(cfg_fsext) << FLW);
  assign e_wlen = idle ? cfg_wlen      : a_wlen;
  assign e_msb  = idle ? cfg_msb_first : a_msb;
  assign e_nw   = idle ? cfg_nwords    : a_nw;
  assign e_len  = idle ? live_len      : a_len;
  assign e_loop = idle ? cfg_loop      : a_loop;
  assign e_cmp  = idle ? cfg_cmp_start : a_cmp;
  assign e_c0   = idle ? cmp_val0      : a_c0;
  assign e_c1   = idle ? cmp_val1      : a_c1;
  assign e_wfix = (e_wlen == '0) ? WLW'(1) : e_wlen;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_wlen <= WLW'(1); a_msb <= 1'b0; a_nw <= '0; a_len <= '0;
      a_loop <= 1'b0;    a_cmp <= 1'b0; a_c0 <= '0; a_c1 <= '0;
    end else if (idle) begin
      a_wlen <= cfg_wlen;  a_msb <= cfg_msb_first; a_nw <= cfg_nwords;
      a_len  <= live_len;  a_loop <= cfg_loop;     a_cmp <= cfg_cmp_start;
      a_c0   <= cmp_val0;  a_c1 <= cmp_val1;
    end
  end

  logic bit_edge, bit_val, fs_val;
  sync_rx_front #(.NL(3)) u_front (
    .clk(clk), .rst(rst), .use_tx(e_loop),
    .rx_lines({rx_fsync, rx_sdata, rx_sclk}),
    .tx_lines({tx_fsync, tx_sdata, tx_sclk}),
    .bit_edge(bit_edge), .bit_val(bit_val), .fs_val(fs_val)
  );

  logic [SW-1:0]  sync_sh, hunt_sh, hunt_nxt, sync_nxt, sync_mask;
  logic [LW-1:0]  sync_cnt;
  logic [NWW-1:0] word_cnt;
  logic [CW-1:0]  hunt_cnt, e_n;
  logic fs_prev, fs_rise, enough, hit0, hit1, start_now, asm_en, asm_last;

  assign e_n       = (e_len >= LW'(SW - 1)) ? CW'(SW) : CW'(e_len + LW'(1));
  assign sync_mask = (e_n == CW'(SW)) ? '1 : ((SW'(1) << e_n) - SW'(1));
  assign hunt_nxt  = {hunt_sh[SW-2:0], bit_val};
  assign sync_nxt  = {sync_sh[SW-2:0], bit_val};
  assign enough    = (hunt_cnt >= e_n - CW'(1));
  assign hit0      = ((hunt_nxt ^ e_c0) & sync_mask) == '0;
  assign hit1      = ((hunt_nxt ^ e_c1) & sync_mask) == '0;
  assign fs_rise   = bit_edge & fs_val & ~fs_prev;
  assign start_now = bit_edge & idle & (e_cmp ? (enough & (hit0 | hit1)) : fs_rise);
  assign asm_en    = bit_edge & (state == RX_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RX_IDLE;   sync_sh <= '0;  sync_cnt <= '0; word_cnt <= '0;
      hunt_sh <= '0;      hunt_cnt <= '0; fs_prev <= 1'b0;
      sync_data <= '0;    sync_valid <= 1'b0; cmp_hit <= 1'b0;
      overrun <= 1'b0;    cfg_error <= 1'b0;
    end else begin
      sync_valid <= 1'b0;
      cmp_hit    <= 1'b0;
      if (idle && cfg_wlen == '0) cfg_error <= 1'b1;
      if (bit_edge) fs_prev <= fs_val;
      if (fs_rise && !idle) overrun <= 1'b1;
      unique case (state)
        RX_IDLE: if (bit_edge) begin
          hunt_sh <= hunt_nxt;
          if (hunt_cnt != CW'(SW)) hunt_cnt <= hunt_cnt + CW'(1);
          if (start_now) begin
            word_cnt <= '0;
            if (e_cmp) begin
              sync_data  <= hunt_nxt & sync_mask;
              sync_valid <= 1'b1;
              cmp_hit    <= 1'b1;
              state      <= RX_DATA;
            end else if (e_len == '0) begin
              sync_data  <= SW'(bit_val);
              sync_valid <= 1'b1;
              state      <= RX_DATA;
            end else begin
              sync_sh  <= SW'(bit_val);
              sync_cnt <= LW'(1);
              state    <= RX_SYNC;
            end
          end
        end
        RX_SYNC: if (bit_edge) begin
          sync_sh  <= sync_nxt;
          sync_cnt <= sync_cnt + LW'(1);
          if (sync_cnt == e_len) begin
            sync_data  <= sync_nxt;
            sync_valid <= 1'b1;
            state      <= RX_DATA;
          end
        end
        RX_DATA: if (asm_en && asm_last) begin
          if (word_cnt == e_nw) begin
            state    <= RX_IDLE;
            hunt_sh  <= '0;
            hunt_cnt <= '0;
          end else begin
            word_cnt <= word_cnt + NWW'(1);
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  sync_rx_word #(.DW(DW), .WLW(WLW)) u_word (
    .clk(clk), .rst(rst), .en(asm_en), .bit_in(bit_val),
    .wlen_m1(e_wfix), .msb_first(e_msb), .last(asm_last),
    .word_data(word_data), .word_valid(word_valid)
  );

  sync_rx_fsgen #(.LW(LW)) u_fs (
    .clk(clk), .rst(rst), .start(start_now), .bit_edge(bit_edge),
    .len(e_len), .fs_out(fs_drive)
  );

  // R9
  cfg_error_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_error |=> cfg_error);
  // R11
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
  // R4
  sync_done_chk: assert property (@(posedge clk) disable iff (rst)
    sync_valid |-> state == RX_DATA);
  // R6
  cmp_hit_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_hit |-> $past(idle) && sync_valid);
  // R3
  word_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> $past(state == RX_DATA));
endmodule

// File: tb/sync_serial_rx_test.sv
module sync_serial_rx_test;
  logic clk = 1'b0, rst = 1'b1;
  logic rx_sclk = 0, rx_sdata = 0, rx_fsync = 0;
  logic tx_sclk = 0, tx_sdata = 0, tx_fsync = 0;
  logic [4:0]  cfg_wlen = 5'd7;
  logic        cfg_msb_first = 0, cfg_loop = 0, cfg_cmp_start = 0;
  logic [3:0]  cfg_nwords = 0, cfg_fslen = 0, cfg_fsext = 0;
  logic [15:0] cmp_val0 = 0, cmp_val1 = 0;
  logic [31:0] word_data;
  logic [15:0] sync_data;
  logic word_valid, sync_valid, cmp_hit, fs_drive, cfg_error, overrun;

  int total = 0, bad = 0;
  logic use_tx = 0;
  logic [31:0] got_q[$];
  logic [15:0] got_sync;
  int nsync = 0, ncmp = 0, fs_run = 0, fs_len_last = 0, fs_pulses = 0;

  always #10 clk = ~clk;

  sync_serial_rx uut (
    .clk(clk), .rst(rst), .rx_sclk(rx_sclk), .rx_sdata(rx_sdata), .rx_fsync(rx_fsync),
    .tx_sclk(tx_sclk), .tx_sdata(tx_sdata), .tx_fsync(tx_fsync),
    .cfg_wlen(cfg_wlen), .cfg_msb_first(cfg_msb_first), .cfg_nwords(cfg_nwords),
    .cfg_fslen(cfg_fslen), .cfg_fsext(cfg_fsext), .cfg_loop(cfg_loop),
    .cfg_cmp_start(cfg_cmp_start), .cmp_val0(cmp_val0), .cmp_val1(cmp_val1),
    .word_data(word_data), .word_valid(word_valid), .sync_data(sync_data),
    .sync_valid(sync_valid), .cmp_hit(cmp_hit), .fs_drive(fs_drive),
    .cfg_error(cfg_error), .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(negedge clk) if (!rst) begin
    if (word_valid) got_q.push_back(word_data);
    if (sync_valid) begin got_sync = sync_data; nsync++; end
    if (cmp_hit) ncmp++;
    if (fs_drive) fs_run++;
    else if (fs_run != 0) begin fs_len_last = fs_run; fs_run = 0; fs_pulses++; end
  end

  task automatic junk_rx();
    rx_sclk = 1'($urandom); rx_sdata = 1'($urandom); rx_fsync = 1'($urandom);
  endtask

  // one serial bit: 4 system cycles low, 4 high
  task automatic drive_bit(input logic d, input logic f);
    if (use_tx) begin tx_sdata = d; tx_fsync = f; tx_sclk = 0; junk_rx(); end
    else begin rx_sdata = d; rx_fsync = f; rx_sclk = 0; end
    repeat (4) @(negedge clk);
    if (use_tx) begin tx_sclk = 1; junk_rx(); end else rx_sclk = 1;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] wmask(input int w);
    return 32'(((64'd1 << w) - 64'd1));
  endfunction

  task automatic run_frame(input int wl, input int msb, input int nw, input int fl,
                           input int fe, input int cmpm, input int loopm,
                           input int perturb, input int ovr, input int sel1);
    int W, L, N, p0, s0, c0;
    logic [31:0] expw[16];
    logic [15:0] exp_sync, pat, smask;
    string tag;
    cfg_wlen = 5'(wl); cfg_msb_first = 1'(msb); cfg_nwords = 4'(nw);
    cfg_fslen = 4'(fl); cfg_fsext = 4'(fe); cfg_cmp_start = 1'(cmpm);
    cfg_loop = 1'(loopm); use_tx = 1'(loopm);
    W = (wl == 0) ? 2 : wl + 1;
    L = fl + 16 * fe;
    N = (L + 1 > 16) ? 16 : L + 1;
    smask = 16'(wmask(N));
    exp_sync = '0;
    pat = 16'($urandom);
    pat[N-1] = 1'b1;
    if (sel1 != 0) begin cmp_val1 = pat; cmp_val0 = (N > 1) ? pat ^ 16'd1 : pat; end
    else begin cmp_val0 = pat; cmp_val1 = (N > 1) ? pat ^ 16'd1 : pat; end
    got_q.delete();
    p0 = fs_pulses; s0 = nsync; c0 = ncmp;
    for (int i = 0; i < N + 2; i++) drive_bit(1'b0, 1'b0);
    if (cmpm != 0) begin
      for (int i = N - 1; i >= 0; i--) drive_bit(pat[i], 1'b0);
      exp_sync = pat & smask;
    end else begin
      for (int i = 0; i <= L; i++) begin
        logic b = 1'($urandom);
        drive_bit(b, 1'b1);
        exp_sync = {exp_sync[14:0], b};
      end
      exp_sync = exp_sync & smask;
    end
    for (int w = 0; w <= nw; w++) begin
      expw[w] = $urandom & wmask(W);
      for (int k = 0; k < W; k++) begin
        int idx = (msb != 0) ? W - 1 - k : k;
        drive_bit(expw[w][idx], 1'((ovr != 0) && w == 0 && k == 1));
        if (perturb != 0 && w == 0 && k == 0) begin
          cfg_wlen = 5'((wl % 30) + 2); cfg_msb_first = ~cfg_msb_first;
          cfg_nwords = 4'(nw ^ 3); cfg_fslen = ~cfg_fslen;
          cfg_cmp_start = ~cfg_cmp_start;
        end
      end
    end
    for (int i = 0; i < L + 4; i++) drive_bit(1'b0, 1'b0);
    cfg_wlen = 5'd7;
    tag = (perturb != 0) ? "R10" : (ovr != 0) ? "R11" : (loopm != 0) ? "R8" : "R3";
    check(got_q.size() == nw + 1, tag, "word count", got_q.size(), nw + 1);
    for (int w = 0; w <= nw && w < got_q.size(); w++)
      check(got_q[w] == expw[w], (wl == 0) ? "R9 R1" : (msb != 0) ? "R1 R2 msb" : "R1 R2 lsb",
            "word", got_q[w], expw[w]);
    check(nsync == s0 + 1 && got_sync == exp_sync, (cmpm != 0) ? "R6" : "R4 R5",
          "sync data", got_sync, exp_sync);
    check(ncmp == c0 + ((cmpm != 0) ? 1 : 0), "R6", "compare hits", ncmp - c0, cmpm);
    check(fs_pulses == p0 + 1 && fs_len_last == (L + 1) * 8, "R7", "fs pulse cycles",
          fs_len_last, (L + 1) * 8);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check(word_data == 0 && word_valid == 0 && sync_data == 0 && sync_valid == 0 &&
          cmp_hit == 0 && fs_drive == 0 && cfg_error == 0 && overrun == 0,
          "R12", "outputs after reset", {word_valid, sync_valid, cmp_hit, fs_drive,
          cfg_error, overrun}, 0);
    // directed boundaries
    run_frame(31, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    run_frame(31, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    run_frame(1, 0, 3, 0, 0, 0, 0, 0, 0, 0);
    run_frame(6, 1, 2, 0, 1, 0, 0, 0, 0, 0);
    run_frame(9, 0, 0, 15, 2, 0, 0, 0, 0, 0);
    for (int i = 0; i < 10; i++)
      run_frame(1 + ($urandom % 31), $urandom % 2, $urandom % 4, $urandom % 16,
                $urandom % 3, 0, 0, 0, 0, 0);
    check(cfg_error == 0, "R9", "no error on legal lengths", cfg_error, 0);
    check(overrun == 0, "R11", "no overrun on clean frames", overrun, 0);
    // R8 loopback with random activity on the receive pins
    for (int i = 0; i < 3; i++)
      run_frame(1 + ($urandom % 31), $urandom % 2, $urandom % 3, $urandom % 16,
                $urandom % 2, 0, 1, 0, 0, 0);
    // R6 pattern starts
    run_frame(7, 1, 1, 7, 0, 1, 0, 0, 0, 0);
    run_frame(12, 0, 0, 7, 0, 1, 0, 0, 0, 1);
    run_frame(15, 1, 1, 3, 1, 1, 0, 0, 0, 0);
    run_frame(4, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++)
      run_frame(1 + ($urandom % 31), $urandom % 2, $urandom % 3, $urandom % 16,
                $urandom % 2, 1, $urandom % 2, 0, 0, $urandom % 2);
    // R10 mid-frame configuration changes
    run_frame(10, 1, 2, 2, 0, 0, 0, 1, 0, 0);
    run_frame(5, 0, 1, 5, 0, 1, 0, 1, 0, 1);
    // R11 start edge during a frame
    run_frame(8, 0, 1, 1, 0, 0, 0, 0, 1, 0);
    check(overrun == 1, "R11", "overrun set", overrun, 1);
    run_frame(8, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    check(overrun == 1, "R11", "overrun stays", overrun, 1);
    // R9 zero length handled as two bits
    run_frame(0, 1, 3, 0, 0, 0, 0, 0, 0, 0);
    check(cfg_error == 1, "R9", "error flag set", cfg_error, 1);
    run_frame(3, 0, 0, 2, 0, 0, 0, 0, 0, 0);
    check(cfg_error == 1, "R9", "error flag stays", cfg_error, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule